// File: doc/BRIEF.md
# Multi-level capture trigger sequencer

This block decides when a logic-analyzer capture engine starts recording. Four condition detectors outside the block each raise a match line. Each line feeds one trigger stage. A stage waits a programmed number of clock cycles after its match, then takes one of two actions: it starts capture, or it raises a shared 2-bit trigger level. A stage only accepts a match when the current level is at or above the minimum set for that stage. Stages can therefore be chained into an ordered sequence of conditions. An external trigger line bypasses all of this and starts capture directly.

Software sets up each stage through a small write port while the sequencer is disarmed. It then raises the arm line. Rearming is a falling then rising edge on that line. It clears the level and the capture flag and gives every stage a fresh single shot. The capture flag stays high once set, so downstream logic can use it as a level.

Top module: `trig_seq`

## Requirements
- R1: After reset, `run_o`, `armed_o` and `level_o` are 0. Every stage has a delay of 0, the raise action and a minimum level of 0.
- R2: The cycle in which `arm_i` is first seen high is the arming cycle. It clears `level_o` and `run_o` at the next edge, and `armed_o` is high from the next cycle on. A match present during the arming cycle itself is ignored.
- R3: With delay 0, a qualifying match in cycle t takes effect on the outputs in cycle t+1.
- R4: With delay D > 0, a qualifying match in cycle t takes effect in cycle t+1+D. The match line is not examined again during the wait, so the action happens even if the line drops.
- R5: A stage acts at most once per arming. Further matches on that stage have no effect until the next arming.
- R6: A match is qualifying only when `level_o` is greater than or equal to the stage's minimum level. A non-qualifying match is ignored, and the stage keeps watching.
- R7: The level is 2 bits wide. Raising it from 3 gives 0.
- R8: If several stages raise the level in the same cycle, the level increases by exactly one.
- R9: A stage whose action is start (`cfg_start_i` = 1 when written; 0 selects raise) sets `run_o`. `run_o` stays high until reset or the next arming, including while disarmed. The start action does not change the level.
- R10: While armed, `ext_trig_i` high in cycle t sets `run_o` in cycle t+1, whatever the level or stage states.
- R11: A configuration write (`cfg_we_i` high, stage chosen by `cfg_sel_i`) takes effect only while `armed_o` is low. A write while armed is ignored.
- R12: While `armed_o` is low, match inputs do not change `level_o` or `run_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm_i | input | 1 | Arm request. The sequencer is armed while this line is high; a rising edge starts a new arming |
| ext_trig_i | input | 1 | External trigger; starts capture when armed |
| match_i | input | NSTG | Per-stage match lines from the condition detectors |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | $clog2(NSTG) | Stage addressed by the write |
| cfg_delay_i | input | DW | Delay in clock cycles to write |
| cfg_start_i | input | 1 | Action to write: 1 = start capture, 0 = raise level |
| cfg_level_i | input | LW | Minimum level to write |
| armed_o | output | 1 | Sequencer armed |
| level_o | output | LW | Current trigger level |
| run_o | output | 1 | Capture start, sticky |

## Verification
Two stage actions can land on the shared level register in the same cycle. The bench provokes this by driving two raise-action matches together, and it expects the level to go up by exactly one. A level raise can also coincide with another stage qualifying against that level. The bench covers this by holding a gated stage pending while an earlier stage raises the level, then matching it again in the first cycle the new level is visible. It judges the result by the cycle in which delayed capture appears.

// File: rtl/trig_seq.sv
module trig_seq #(
  parameter int NSTG = 4,
  parameter int DW   = 16,
  parameter int LW   = 2,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm_i,
  input  logic            ext_trig_i,
  input  logic [NSTG-1:0] match_i,
  input  logic            cfg_we_i,
  input  logic [SW-1:0]   cfg_sel_i,
  input  logic [DW-1:0]   cfg_delay_i,
  input  logic            cfg_start_i,
  input  logic [LW-1:0]   cfg_level_i,
  output logic            armed_o,
  output logic [LW-1:0]   level_o,
  output logic            run_o
);

  typedef enum logic [1:0] {S_OFF, S_WATCH, S_WAIT, S_DONE} stage_e;

  logic                     armed_q, run_q;
  logic [LW-1:0]            lvl_q;
  logic [NSTG-1:0][DW-1:0]  dly_q;
  logic [NSTG-1:0][LW-1:0]  min_q;
  logic [NSTG-1:0]          act_q;
  logic [NSTG-1:0]          fire;
  stage_e                   st_q [NSTG];

  wire arm_rise = arm_i && !armed_q;
  wire cfg_ok   = cfg_we_i && !armed_q;
  wire do_raise = |(fire & ~act_q);
  wire do_start = |(fire & act_q);

  assign armed_o = armed_q;
  assign level_o = lvl_q;
  assign run_o   = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      run_q   <= 1'b0;
      lvl_q   <= '0;
    end else begin
      armed_q <= arm_i;
      if (arm_rise) begin
        run_q <= 1'b0;
        lvl_q <= '0;
      end else if (armed_q) begin
        if (do_raise) lvl_q <= lvl_q + 1'b1;
        if (do_start || ext_trig_i) run_q <= 1'b1;
      end
    end
  end

  for (genvar s = 0; s < NSTG; s++) begin : g_stage
    logic [DW-1:0] cnt_q;
    wire hit = match_i[s] && (lvl_q >= min_q[s]);

    assign fire[s] = armed_q &&
                     ((st_q[s] == S_WATCH && hit && dly_q[s] == '0) ||
                      (st_q[s] == S_WAIT && cnt_q == DW'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dly_q[s] <= '0;
        min_q[s] <= '0;
        act_q[s] <= 1'b0;
      end else if (cfg_ok && cfg_sel_i == SW'(s)) begin
        dly_q[s] <= cfg_delay_i;
        min_q[s] <= cfg_level_i;
        act_q[s] <= cfg_start_i;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[s] <= S_OFF;
        cnt_q   <= '0;
      end else if (arm_rise) begin
        st_q[s] <= S_WATCH;
        cnt_q   <= '0;
      end else if (!armed_q) begin
        st_q[s] <= S_OFF;
      end else begin
        case (st_q[s])
          S_WATCH: if (hit) begin
            if (dly_q[s] == '0) st_q[s] <= S_DONE;
            else begin
              st_q[s] <= S_WAIT;
              cnt_q   <= dly_q[s];
            end
          end
          S_WAIT: begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == DW'(1)) st_q[s] <= S_DONE;
          end
          default: ;
        endcase
      end
    end

    p_one_shot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[s] == S_DONE && !arm_rise) |=> (st_q[s] == S_DONE || st_q[s] == S_OFF));
  end

  p_arm_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    arm_rise |=> (armed_q && !run_q && lvl_q == '0));

  p_level_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !arm_rise) |=> (lvl_q == $past(lvl_q) || lvl_q == LW'($past(lvl_q) + 1'b1)));

  p_run_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !arm_rise) |=> run_q);

  p_ext_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ext_trig_i) |=> run_q);

  p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |=> ($stable(dly_q) && $stable(min_q) && $stable(act_q)));

  p_idle_level_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_rise) |=> ($stable(lvl_q) && (run_q == $past(run_q))));

endmodule

// File: tb/trig_seq_tb.sv
module trig_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic arm_i = 1'b0, ext_trig_i = 1'b0, cfg_we_i = 1'b0, cfg_start_i = 1'b0;
  logic [3:0]  match_i = '0;
  logic [1:0]  cfg_sel_i = '0, cfg_level_i = '0;
  logic [15:0] cfg_delay_i = '0;
  logic armed_o, run_o;
  logic [1:0] level_o;

  always #5 clk = ~clk;

  trig_seq dut_i (
    .clk(clk), .rst_n(rst_n), .arm_i(arm_i), .ext_trig_i(ext_trig_i),
    .match_i(match_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
    .cfg_delay_i(cfg_delay_i), .cfg_start_i(cfg_start_i), .cfg_level_i(cfg_level_i),
    .armed_o(armed_o), .level_o(level_o), .run_o(run_o)
  );

  typedef struct {
    int at; logic a; logic r; logic [1:0] l; string tag;
  } item_t;

  item_t q[$];
  int cyc = 0, n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic exp_at(int at, logic a, logic r, logic [1:0] l, string tag);
    item_t it;
    int k;
    it.at = at; it.a = a; it.r = r; it.l = l; it.tag = tag;
    k = 0;
    while (k < q.size() && q[k].at <= at) k++;
    q.insert(k, it);
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [15:0] dly, logic st, logic [1:0] lv);
    step();
    cfg_we_i = 1'b1; cfg_sel_i = sel; cfg_delay_i = dly; cfg_start_i = st; cfg_level_i = lv;
    step();
    cfg_we_i = 1'b0;
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      item_t it;
      it = q.pop_front();
      n_chk++;
      if (it.at < cyc || armed_o !== it.a || run_o !== it.r || level_o !== it.l) begin
        n_bad++;
        $display("FAIL %s cycle %0d: armed/run/level = %0b/%0b/%0d, expected %0b/%0b/%0d",
                 it.tag, it.at, armed_o, run_o, level_o, it.a, it.r, it.l);
      end
    end
  end

  task automatic finish_run();
    if (q.size() > 0) begin
      n_bad += q.size(); n_chk += q.size();
      $display("FAIL pending: %0d checks never reached, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    finish_run();
  end

  initial begin
    int n, c;
    repeat (3) step();
    rst_n = 1'b1;
    exp_at(cyc, 0, 0, 0, "R1 reset");

    // R2: arming cycle, match in it ignored
    step(); arm_i = 1'b1; match_i = 4'b0001; n = cyc;
    exp_at(n, 0, 0, 0, "R2 not yet armed");
    exp_at(n + 1, 1, 0, 0, "R2 armed next cycle");
    step(); match_i = '0;
    exp_at(n + 2, 1, 0, 0, "R2 match in arming cycle ignored");

    // R3 zero delay raises with default config (R1), R7 wrap
    step(); match_i = 4'b0001; c = cyc; exp_at(c + 1, 1, 0, 1, "R3 R1 stage0 raise");
    step(); match_i = 4'b0010; c = cyc; exp_at(c + 1, 1, 0, 2, "R3 stage1 raise");
    step(); match_i = 4'b0100; c = cyc; exp_at(c + 1, 1, 0, 3, "R3 stage2 raise");
    step(); match_i = 4'b1000; c = cyc; exp_at(c + 1, 1, 0, 0, "R7 wrap 3 to 0");
    // R5 one shot
    step(); match_i = 4'b0001; c = cyc;
    exp_at(c + 1, 1, 0, 0, "R5 second match ignored");
    step(); match_i = '0;
    exp_at(c + 2, 1, 0, 0, "R5 still ignored");

    // R8 concurrent raise
    step(); arm_i = 1'b0;
    step(); arm_i = 1'b1; n = cyc;
    exp_at(n + 1, 1, 0, 0, "R2 rearm clears level");
    step(); match_i = 4'b0011; c = cyc;
    exp_at(c + 1, 1, 0, 1, "R8 two raises give one step");
    step(); match_i = '0;
    exp_at(c + 2, 1, 0, 1, "R8 level held");

    // configure stage2: delay 3, start, min level 1
    step(); arm_i = 1'b0; c = cyc;
    exp_at(c + 1, 0, 0, 1, "R12 disarmed keeps level");
    cfg_write(2'd2, 16'd3, 1'b1, 2'd1);
    step(); arm_i = 1'b1; n = cyc;
    exp_at(n + 1, 1, 0, 0, "R2 armed");
    step(); match_i = 4'b0100; c = cyc;
    exp_at(c + 1, 1, 0, 0, "R6 gated by level");
    step(); match_i = 4'b0001; c = cyc;
    exp_at(c + 1, 1, 0, 1, "R6 stage0 lifts level");
    step(); match_i = 4'b0100; c = cyc;
    exp_at(c + 1, 1, 0, 1, "R4 waiting");
    exp_at(c + 3, 1, 0, 1, "R4 no run before delay");
    exp_at(c + 4, 1, 1, 1, "R4 R9 run after delay, level kept");
    step(); match_i = '0;
    repeat (6) step();
    exp_at(cyc, 1, 1, 1, "R9 run sticky");

    // R11 write while armed is ignored
    cfg_write(2'd2, 16'd0, 1'b0, 2'd0);
    step(); arm_i = 1'b0; c = cyc;
    exp_at(c + 1, 0, 1, 1, "R9 run kept when disarmed");
    step(); match_i = 4'b0010; c = cyc;
    exp_at(c + 1, 0, 1, 1, "R12 match while disarmed");
    step(); match_i = '0;
    step(); arm_i = 1'b1; n = cyc;
    exp_at(n + 1, 1, 0, 0, "R9 rearm clears run");
    step(); match_i = 4'b0001;
    step(); match_i = 4'b0100; c = cyc;
    exp_at(c, 1, 0, 1, "R11 level before stage2");
    exp_at(c + 1, 1, 0, 1, "R11 old delay kept");
    exp_at(c + 4, 1, 1, 1, "R11 old start action kept");
    step(); match_i = '0;
    repeat (5) step();

    // R10 external trigger
    step(); arm_i = 1'b0;
    step(); arm_i = 1'b1;
    step(); ext_trig_i = 1'b1; c = cyc;
    exp_at(c, 1, 0, 0, "R10 before ext");
    exp_at(c + 1, 1, 1, 0, "R10 ext sets run at level 0");
    step(); ext_trig_i = 1'b0;
    repeat (3) step();
    exp_at(cyc, 1, 1, 0, "R10 R9 run held");
    step(); step();
    finish_run();
  end
endmodule